// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Mode Controller

This block holds the control state for the power-saving modes of a pseudo-SRAM. An active-low sleep pin, `zz_n`, opens a timed window of `CLK_PER_US` clock cycles, which represents one microsecond. During that window a 5-bit mode word can be written through a strobe. When the window closes with the pin still low, the controller enters one of two standby states. In partial-refresh standby the refresh keeps going, limited to one chosen region. In deep sleep the refresh stops and the array contents count as lost.

A reduced-size setting clips the array address so that only the lower half or the lower quarter of the array can be reached. It takes effect at the next rising edge of `zz_n`, and it stays in force until a new word is written and a later wake-up picks that word up. Entering deep sleep puts the mode word back to its build-time default. The parameter `DSA_DEFAULT` picks that default. With `DSA_DEFAULT` = 1, a long sleep enters deep sleep. With `DSA_DEFAULT` = 0, a long sleep enters partial-refresh standby.

The refresh engine and the array sit outside this block. It only drives their address clip, their refresh region and their refresh enable, and it reports a state code and a data-lost flag.

Top module: `psram_pwr_ctrl`

## Requirements
- R1: After reset the block is in the following state:
  - `pwr_state` = 0 (active) and `refresh_en` = 1.
  - `data_lost` = 0.
  - `ref_span` = 0 (full) and `ref_part_sel` = 0.
  - `addr_out` equals `addr_in`.
- R2: A `cfg_we` strobe loads `cfg_bits` only on the first `CLK_PER_US` rising clock edges that sample `zz_n` low. A strobe on any later edge of the same low period leaves the stored word unchanged.
- R3: The mode word has the following fields:
  - [1:0] is the size or partition: 0 = full, 1 = half, 2 = quarter, 3 = full.
  - Bit 2 = 1 selects reduced size, and bit 2 = 0 selects partial refresh.
  - Bit 3 picks the upper region (1) or the lower region (0).
  - Bit 4 = 1 disables deep sleep.

  Reduced size is applied at a rising edge of `zz_n`. At that point `addr_out` has its top bit (half) or its top two bits (quarter) forced to 0. Before that rising edge `addr_out` is unchanged.
- R4: A reduced size stays in force across later sleep/wake cycles that carry no write.
- R5: In partial-refresh standby (`pwr_state` = 1), with bit 2 = 0, `ref_span` and `ref_part_sel` show bits [1:0] and bit 3 of the word. In every other case they read full (0) and 0.
- R6: The state changes when `zz_n` has been sampled low on `CLK_PER_US`+1 edges:
  - If bit 4 = 0, the block enters deep sleep (`pwr_state` = 2) and `refresh_en` drops to 0. It stays there as long as `zz_n` is low.
  - If bit 4 = 1, the block enters partial-refresh standby (`pwr_state` = 1).
- R7: Entering deep sleep restores the mode word to its default, so the next wake-up sets full addressing.
- R8: `data_lost` rises when deep sleep is entered. It then holds until the first edge at which `acc_valid` is 1 with `zz_n` high.
- R9: With `DSA_DEFAULT` = 0, a long low period with no write gives partial-refresh standby and never deep sleep.
- R10: The block stays active (`pwr_state` = 0) through the first `CLK_PER_US` low edges. A write on the last of those edges still decides which standby state follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zz_n | input | 1 | Active-low sleep request pin |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_bits | input | 5 | Mode word carried on address lines |
| acc_valid | input | 1 | Array access strobe |
| addr_in | input | ADDR_W | Array address from the host side |
| addr_out | output | ADDR_W | Array address after the size clip |
| refresh_en | output | 1 | Refresh engine enable |
| ref_span | output | 2 | Refresh region size (0 full, 1 half, 2 quarter) |
| ref_part_sel | output | 1 | Refresh region select (upper when 1) |
| pwr_state | output | 2 | 0 active, 1 partial-refresh standby, 2 deep sleep |
| data_lost | output | 1 | Array contents invalid since deep sleep |

## Verification
The assertions assume that `zz_n`, `cfg_we` and `acc_valid` are already synchronous to `clk`. They also assume that a write strobe outside the window is harmless rather than illegal, so the window properties check only stored-state stability. The bench changes every input one nanosecond after a rising edge and holds it for whole cycles, so each sleep period is an exact number of sampled low edges. The bench drives late writes on purpose, to show that they are ignored.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    PS_ACT  = 2'd0,
    PS_PAR  = 2'd1,
    PS_DEEP = 2'd2
  } pwr_state_e;

  typedef enum logic [1:0] {
    SP_FULL = 2'd0,
    SP_HALF = 2'd1,
    SP_QTR  = 2'd2,
    SP_RSVD = 2'd3
  } span_e;

  typedef struct packed {
    logic  ds_off;
    logic  part_sel;
    logic  rms_mode;
    span_e span;
  } mode_cfg_t;

  function automatic mode_cfg_t cfg_default(input bit dsa);
    mode_cfg_t c;
    c.ds_off   = ~dsa;
    c.part_sel = 1'b0;
    c.rms_mode = 1'b0;
    c.span     = SP_FULL;
    return c;
  endfunction

  function automatic span_e span_norm(input span_e s);
    return (s == SP_RSVD) ? SP_FULL : s;
  endfunction

endpackage

// File: rtl/psram_us_window.sv
module psram_us_window #(
  parameter int CLK_PER_US = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zz_n,
  output logic win_open,
  output logic win_done
);
  localparam int CW = $clog2(CLK_PER_US + 1);
  localparam logic [CW-1:0] LIM = CW'(CLK_PER_US);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = zz_n || (cnt_q != LIM);
    cnt_d  = zz_n ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign win_open = !zz_n && (cnt_q != LIM);
  assign win_done = !zz_n && (cnt_q == LIM);

  // R10
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R10
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zz_n |=> (cnt_q == '0));
endmodule

// File: rtl/psram_mode_reg.sv
module psram_mode_reg
  import psram_pwr_pkg::*;
#(
  parameter bit DSA_DEFAULT = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      zz_n,
  input  logic      wr_en,
  input  mode_cfg_t cfg_in,
  input  logic      wipe,
  output mode_cfg_t cfg_q,
  output span_e     rms_span
);
  localparam mode_cfg_t DEF = cfg_default(DSA_DEFAULT);

  mode_cfg_t cfg_d;
  span_e     span_q, span_d;
  logic      zz_q, wake;

  always_comb begin
    wake   = zz_n && !zz_q;
    cfg_d  = wipe ? DEF : cfg_in;
    span_d = cfg_q.rms_mode ? span_norm(cfg_q.span) : SP_FULL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= DEF;
      span_q <= SP_FULL;
      zz_q   <= 1'b1;
    end else begin
      zz_q <= zz_n;
      if (wipe || wr_en) cfg_q  <= cfg_d;
      if (wake)          span_q <= span_d;
    end
  end

  assign rms_span = span_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wipe) |=> $stable(cfg_q));
  // R7
  cfg_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (cfg_q == DEF));
  // R3
  span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz_n || zz_q) |=> $stable(span_q));
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       zz_n,
  input  logic       win_done,
  input  logic       ds_off,
  input  logic       acc_valid,
  output pwr_state_e state_q,
  output logic       lost_q,
  output logic       deep_enter
);
  pwr_state_e state_d;
  logic       lost_d, lost_en;

  always_comb begin
    deep_enter = !zz_n && win_done && (state_q == PS_ACT) && !ds_off;
    state_d    = state_q;
    if (zz_n)
      state_d = PS_ACT;
    else if ((state_q == PS_ACT) && win_done)
      state_d = ds_off ? PS_PAR : PS_DEEP;
    lost_en = deep_enter || (zz_n && acc_valid);
    lost_d  = deep_enter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_ACT;
      lost_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (lost_en) lost_q <= lost_d;
    end
  end

  // R6
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DEEP && !zz_n) |=> (state_q == PS_DEEP));
  // R6
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DEEP && $past(state_q) != PS_DEEP) |-> ($past(state_q) == PS_ACT));
  // R8
  deep_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DEEP) |-> lost_q);
endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
  import psram_pwr_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int CLK_PER_US  = 250,
  parameter bit DSA_DEFAULT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zz_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_bits,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              refresh_en,
  output logic [1:0]        ref_span,
  output logic              ref_part_sel,
  output logic [1:0]        pwr_state,
  output logic              data_lost
);
  logic       win_open, win_done, deep_enter, par_live;
  mode_cfg_t  cfg_q;
  span_e      rms_span;
  pwr_state_e state_q;

  psram_us_window #(.CLK_PER_US(CLK_PER_US)) win_i (
    .clk(clk), .rst_n(rst_n), .zz_n(zz_n),
    .win_open(win_open), .win_done(win_done)
  );

  psram_mode_reg #(.DSA_DEFAULT(DSA_DEFAULT)) reg_i (
    .clk(clk), .rst_n(rst_n), .zz_n(zz_n),
    .wr_en(cfg_we && win_open), .cfg_in(mode_cfg_t'(cfg_bits)),
    .wipe(deep_enter), .cfg_q(cfg_q), .rms_span(rms_span)
  );

  psram_pwr_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .win_done(win_done),
    .ds_off(cfg_q.ds_off), .acc_valid(acc_valid),
    .state_q(state_q), .lost_q(data_lost), .deep_enter(deep_enter)
  );

  always_comb begin
    par_live     = (state_q == PS_PAR) && !cfg_q.rms_mode;
    ref_span     = par_live ? span_norm(cfg_q.span) : SP_FULL;
    ref_part_sel = par_live && cfg_q.part_sel;
    refresh_en   = (state_q != PS_DEEP);
    pwr_state    = state_q;
  end

  for (genvar b = 0; b < ADDR_W; b++) begin : g_clip
    if (b == ADDR_W - 1) begin : g_top
      assign addr_out[b] = addr_in[b] && (rms_span == SP_FULL);
    end else if (b == ADDR_W - 2) begin : g_next
      assign addr_out[b] = addr_in[b] && (rms_span != SP_QTR);
    end else begin : g_pass
      assign addr_out[b] = addr_in[b];
    end
  end

  // R6
  ref_off_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_enter) |=> !refresh_en);
endmodule

// File: tb/psram_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module psram_pwr_ctrl_tb_top;
  localparam int AW  = 21;
  localparam int CPU = 16;

  typedef struct packed {
    logic [7:0] rep;
    logic       zz;
    logic       we;
    logic [4:0] cfg;
    logic       acc;
    logic [1:0] e_st;
    logic       e_ref;
    logic       e_lost;
    logic [1:0] e_sp;
    logic       e_sel;
    logic [1:0] e_hi;
  } vec_t;

  // Each row: hold inputs for rep cycles, then compare outputs.
  localparam vec_t TBL [17] = '{
    '{8'd1,  1'b1,1'b0,5'b00000,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b11}, // R1 idle
    '{8'd1,  1'b0,1'b1,5'b10101,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b11}, // R3 not yet
    '{8'd16, 1'b0,1'b0,5'b00000,1'b0, 2'd1,1'b1,1'b0,2'd0,1'b0,2'b11}, // R5 rms->full ref
    '{8'd4,  1'b0,1'b1,5'b00010,1'b0, 2'd1,1'b1,1'b0,2'd0,1'b0,2'b11}, // R2 late write
    '{8'd1,  1'b1,1'b0,5'b00000,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b01}, // R3 R2 half clip
    '{8'd20, 1'b0,1'b0,5'b00000,1'b0, 2'd1,1'b1,1'b0,2'd0,1'b0,2'b01}, // R4
    '{8'd1,  1'b1,1'b0,5'b00000,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b01}, // R4
    '{8'd1,  1'b0,1'b1,5'b11010,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b01}, // R2
    '{8'd16, 1'b0,1'b0,5'b00000,1'b0, 2'd1,1'b1,1'b0,2'd2,1'b1,2'b01}, // R5 quarter upper
    '{8'd1,  1'b1,1'b0,5'b00000,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b11}, // R5 R3 full again
    '{8'd1,  1'b0,1'b1,5'b00101,1'b0, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b11}, // R2
    '{8'd16, 1'b0,1'b0,5'b00000,1'b0, 2'd2,1'b0,1'b1,2'd0,1'b0,2'b11}, // R6 R8
    '{8'd30, 1'b0,1'b0,5'b00000,1'b1, 2'd2,1'b0,1'b1,2'd0,1'b0,2'b11}, // R6 R8 acc while low
    '{8'd1,  1'b1,1'b0,5'b00000,1'b0, 2'd0,1'b1,1'b1,2'd0,1'b0,2'b11}, // R7 R8
    '{8'd1,  1'b1,1'b0,5'b00000,1'b1, 2'd0,1'b1,1'b0,2'd0,1'b0,2'b11}, // R8 clear
    '{8'd17, 1'b0,1'b0,5'b00000,1'b0, 2'd2,1'b0,1'b1,2'd0,1'b0,2'b11}, // R7 default deep
    '{8'd1,  1'b1,1'b0,5'b00000,1'b0, 2'd0,1'b1,1'b1,2'd0,1'b0,2'b11}  // R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zz_n = 1'b1, cfg_we = 1'b0, acc_valid = 1'b0;
  logic [4:0] cfg_bits = '0;
  logic [AW-1:0] addr_in = '1;
  logic [AW-1:0] addr_out;
  logic refresh_en, ref_part_sel, data_lost;
  logic [1:0] ref_span, pwr_state;

  logic s_zz_n = 1'b1;
  logic [AW-1:0] s_addr_out;
  logic s_ref, s_sel, s_lost;
  logic [1:0] s_span, s_state;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  psram_pwr_ctrl #(.ADDR_W(AW), .CLK_PER_US(CPU), .DSA_DEFAULT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .zz_n(zz_n), .cfg_we(cfg_we), .cfg_bits(cfg_bits),
    .acc_valid(acc_valid), .addr_in(addr_in), .addr_out(addr_out),
    .refresh_en(refresh_en), .ref_span(ref_span), .ref_part_sel(ref_part_sel),
    .pwr_state(pwr_state), .data_lost(data_lost)
  );

  psram_pwr_ctrl #(.ADDR_W(AW), .CLK_PER_US(CPU), .DSA_DEFAULT(1'b0)) dsi_i (
    .clk(clk), .rst_n(rst_n), .zz_n(s_zz_n), .cfg_we(1'b0), .cfg_bits(5'b0),
    .acc_valid(1'b0), .addr_in(addr_in), .addr_out(s_addr_out),
    .refresh_en(s_ref), .ref_span(s_span), .ref_part_sel(s_sel),
    .pwr_state(s_state), .data_lost(s_lost)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pack_out();
    return {22'd0, pwr_state, refresh_en, data_lost, ref_span, ref_part_sel, addr_out[AW-1:AW-2]};
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 state", {30'd0, pwr_state}, 32'd0);
    chk("R1 refresh", {31'd0, refresh_en}, 32'd1);
    chk("R1 lost", {31'd0, data_lost}, 32'd0);
    chk("R1 region", {29'd0, ref_span, ref_part_sel}, 32'd0);
    chk("R1 addr", {11'd0, addr_out}, {11'd0, addr_in});
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 17; i++) begin
      zz_n = TBL[i].zz; cfg_we = TBL[i].we; cfg_bits = TBL[i].cfg; acc_valid = TBL[i].acc;
      for (int r = 0; r < int'(TBL[i].rep); r++) step();
      chk($sformatf("R1-table row %0d", i), pack_out(),
          {22'd0, TBL[i].e_st, TBL[i].e_ref, TBL[i].e_lost, TBL[i].e_sp, TBL[i].e_sel, TBL[i].e_hi});
    end
    zz_n = 1'b1; cfg_we = 1'b0; acc_valid = 1'b1;
    step();
    acc_valid = 1'b0;

    // R10: active for CPU low edges; a write on the last one counts
    zz_n = 1'b0;
    for (int r = 0; r < CPU - 1; r++) step();
    cfg_we = 1'b1; cfg_bits = 5'b10000;
    step();
    cfg_we = 1'b0;
    chk("R10 still active", {30'd0, pwr_state}, 32'd0);
    step();
    chk("R10 last-edge write selects standby", {30'd0, pwr_state}, 32'd1);
    chk("R10 refresh kept", {31'd0, refresh_en}, 32'd1);
    zz_n = 1'b1;
    step();
    chk("R10 wake", {30'd0, pwr_state}, 32'd0);

    // R9: deep-sleep-inactive default
    chk("R9 dsi reset", {30'd0, s_state}, 32'd0);
    s_zz_n = 1'b0;
    repeat (40) step();
    chk("R9 dsi standby", {30'd0, s_state}, 32'd1);
    chk("R9 dsi refresh", {31'd0, s_ref}, 32'd1);
    chk("R9 dsi lost", {31'd0, s_lost}, 32'd0);
    s_zz_n = 1'b1;
    step();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule